// File: doc/BRIEF.md
# Character Display Register File with Host Bus Decode

This block is the host-side storage of a four-character LED display controller. A processor reaches it over a parallel bus. The bus has two chip enables of opposite polarity, active-low read and write strobes, a 3-bit address and an 8-bit data path. The block holds one 8-bit register per character position and one 8-bit control register. It exports all of them in parallel to the display engine that scans the LEDs. The pad drivers sit outside the block, so the data path arrives as separate write data, read data and read-data enable signals.

The upper address half selects a character position, with position 0 as the rightmost digit. Bit 7 of a character register is that digit's attribute flag and bits 6:0 hold its character code. The lower address half is a single control register that answers at every address in that half. The top bit of the control register is a memory-clear command. While it is set, every character register is held at zero and character writes are dropped. A later control write with that bit cleared leaves the clear state. The strobes are sampled on the internal clock, and a write takes effect once per strobe assertion.

Top module: `dispreg_bus_if`

## Requirements
- R1: The block is selected only when `sel_lo_n` is 0 and `sel_hi` is 1. With any other enable combination, no register changes and `rdata_oe` stays low.
- R2: When `rd_n` and `wr_n` are both low, the cycle is a no-operation: no register is written and `rdata_oe` is low.
- R3: `rdata_oe` is high only while the block is selected, `rd_n` is low and `wr_n` is high.
- R4: With `addr[2]`=1, `addr[1:0]` selects character register k (0 = rightmost, 3 = leftmost). A read returns that register, and the register appears on `glyph_regs[8k+7:8k]`.
- R5: With `addr[2]`=0, the control register is accessed whatever `addr[1:0]` is. A read at any of those four addresses returns it, and a write at any of them replaces it.
- R6: A write commits exactly once, on the first rising clock edge at which the selected write strobe is seen low. Keeping the strobe low over further edges with different data or address changes nothing more.
- R7: A control write with bit 7 = 1 sets every bit of all four character registers to zero. The zeros are in place by the clock edge at which that write commits.
- R8: While control bit 7 is 1, character writes are ignored and every character register reads back as 0x00.
- R9: A control write with bit 7 = 0 ends the clear state. Character writes that follow take effect again.
- R10: After synchronous reset (`rst_n` low at a clock edge), the control register is 0x00 (blank, no attributes) and `rdata_oe` is low.
- R11: A character register stores all 8 written bits, including the attribute flag in bit 7, and returns them unchanged on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_lo_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address: bit 2 picks character space, bits 1:0 the position |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data toward the bus |
| rdata_oe | output | 1 | Enable for the external data-bus drivers |
| glyph_regs | output | 32 | The four character registers, position k in bits 8k+7:8k |
| ctl_reg | output | 8 | Control register contents |

## Verification
A table of writes and reads first loads four distinct characters and reads each one back. This separates the four positions and exposes any swap of position order. It then sets an attribute byte, which shows whether bit 7 is stored. It also writes and reads the control register through different lower-half addresses, which shows whether the mirror decode ignores `addr[1:0]`. Directed cases then apply each deselecting enable combination and both strobes low together. They also hold the write strobe low while the data changes, which separates edge-triggered commits from level-triggered ones. Finally, a clear, a character write during the clear and a release sequence show whether the clear acts at once, holds, and ends on command.

// File: rtl/dispreg_pkg.sv
// Package: shared constants and types for the display register file.
// Assumes an 8-bit register width with the clear command in the top bit.
package dispreg_pkg;
    localparam int REG_W     = 8;
    localparam int CLR_BIT   = REG_W - 1;
    localparam int CHARS     = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_e;
endpackage

// File: rtl/dispreg_bus_sync.sv
// Module: dispreg_bus_sync
// Classifies the sampled bus state and turns a write strobe into a single
// commit pulse. Assumes the strobes are already stable in the clk domain.
module dispreg_bus_sync
    import dispreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lo_n,
    input  logic sel_hi,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_fire,
    output logic rd_drive
);
    logic selected;
    acc_e acc_kind;
    logic wr_level;
    logic wr_seen_q;

    // Decode the enables and strobes into an access kind.
    always_comb begin
        selected = !sel_lo_n && sel_hi;
        if (!selected)
            acc_kind = ACC_IDLE;
        else begin
            unique case ({!rd_n, !wr_n})
                2'b10:   acc_kind = ACC_READ;
                2'b01:   acc_kind = ACC_WRITE;
                2'b11:   acc_kind = ACC_BOTH;
                default: acc_kind = ACC_IDLE;
            endcase
        end
    end

    // A write level and a read drive exist only for a clean single strobe.
    always_comb begin
        wr_level = (acc_kind == ACC_WRITE);
        rd_drive = (acc_kind == ACC_READ);
    end

    // Remember the write level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_seen_q <= 1'b0;
        else
            wr_seen_q <= wr_level;
    end

    // Commit only on the first sampled edge of a write strobe.
    always_comb wr_fire = wr_level && !wr_seen_q;
endmodule

// File: rtl/dispreg_ctl_reg.sv
// Module: dispreg_ctl_reg
// Holds the single control register. Reset clears it so the display is
// blank and no attribute or clear command is active.
module dispreg_ctl_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    // Load the control byte on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/dispreg_char_bank.sv
// Module: dispreg_char_bank
// One register per character position, flattened onto one output bus.
// Assumes wipe takes priority over writes. Contents are not reset; they
// are defined by the first clear or write.
module dispreg_char_bank #(
    parameter int REG_W = 8,
    parameter int COUNT = 4,
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [REG_W-1:0]       wdata,
    input  logic                   wipe,
    output logic [COUNT*REG_W-1:0] flat
);
    for (genvar k = 0; k < COUNT; k++) begin : g_slot
        logic [REG_W-1:0] slot_q;

        // Zero on wipe, else load when this position is addressed.
        always_ff @(posedge clk) begin
            if (wipe)
                slot_q <= '0;
            else if (we && (idx == IDX_W'(k)))
                slot_q <= wdata;
        end

        // Expose this slot on its lane of the flat bus.
        always_comb flat[k*REG_W +: REG_W] = slot_q;
    end
endmodule

// File: rtl/dispreg_bus_if.sv
// Module: dispreg_bus_if (top)
// Host register file for a multi-character display: decodes the parallel
// bus, stores the character and control bytes, applies the memory clear
// and returns read data. Pad tristate control is external (rdata_oe).
module dispreg_bus_if
    import dispreg_pkg::*;
#(
    parameter int DATA_W   = REG_W,
    parameter int CHAR_CNT = CHARS,
    localparam int IDX_W   = (CHAR_CNT > 1) ? $clog2(CHAR_CNT) : 1,
    localparam int ADDR_W  = IDX_W + 1,
    localparam int CLR_POS = DATA_W - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_lo_n,
    input  logic                       sel_hi,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rdata_oe,
    output logic [CHAR_CNT*DATA_W-1:0] glyph_regs,
    output logic [DATA_W-1:0]          ctl_reg
);
    logic             wr_fire;
    logic             rd_drive;
    logic             char_space;
    logic [IDX_W-1:0] char_idx;
    logic             ctl_we;
    logic             chr_we;
    logic             wipe;
    logic [DATA_W-1:0] ctl_q;
    logic [CHAR_CNT*DATA_W-1:0] chars_flat;

    dispreg_bus_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_fire  (wr_fire),
        .rd_drive (rd_drive)
    );

    // Split the address into space select and position index.
    always_comb begin
        char_space = addr[ADDR_W-1];
        char_idx   = addr[IDX_W-1:0];
    end

    // Route a commit; character writes are blocked while clear is held.
    always_comb begin
        ctl_we = wr_fire && !char_space;
        chr_we = wr_fire && char_space && !ctl_q[CLR_POS];
        wipe   = ctl_q[CLR_POS] || (ctl_we && wdata[CLR_POS]);
    end

    dispreg_ctl_reg #(.REG_W(DATA_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (wdata),
        .q     (ctl_q)
    );

    dispreg_char_bank #(.REG_W(DATA_W), .COUNT(CHAR_CNT)) u_bank (
        .clk   (clk),
        .we    (chr_we),
        .idx   (char_idx),
        .wdata (wdata),
        .wipe  (wipe),
        .flat  (chars_flat)
    );

    // Select read data from the control byte or the addressed character.
    always_comb begin
        if (char_space)
            rdata = chars_flat[int'(char_idx)*DATA_W +: DATA_W];
        else
            rdata = ctl_q;
    end

    // Drive the exported state and the pad enable.
    always_comb begin
        rdata_oe   = rd_drive;
        glyph_regs = chars_flat;
        ctl_reg    = ctl_q;
    end
endmodule

// File: rtl/dispreg_chk.sv
// Module: dispreg_chk
// Checker bound to dispreg_bus_if. Observes ports only.
module dispreg_chk #(
    parameter int DATA_W   = 8,
    parameter int CHAR_CNT = 4,
    localparam int IDX_W   = (CHAR_CNT > 1) ? $clog2(CHAR_CNT) : 1,
    localparam int ADDR_W  = IDX_W + 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sel_lo_n,
    input logic                       sel_hi,
    input logic                       rd_n,
    input logic                       wr_n,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          rdata,
    input logic                       rdata_oe,
    input logic [CHAR_CNT*DATA_W-1:0] glyph_regs,
    input logic [DATA_W-1:0]          ctl_reg
);
    logic sel_now;
    logic wr_now;
    always_comb begin
        sel_now = !sel_lo_n && sel_hi;
        wr_now  = sel_now && !wr_n && rd_n;
    end

    // R1
    deselect_holds_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_now |=> $stable(ctl_reg));

    // R2
    both_strobes_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |-> !rdata_oe);

    // R3
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!rd_n && wr_n && sel_now));

    // R4
    char_read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr[ADDR_W-1]) |->
            (rdata == glyph_regs[int'(addr[IDX_W-1:0])*DATA_W +: DATA_W]));

    // R5
    ctl_mirror_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && !addr[ADDR_W-1]) |-> (rdata == ctl_reg));

    // R6
    held_strobe_no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_now) && wr_now) |=> $stable(ctl_reg));

    // R8
    clear_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reg[DATA_W-1] |-> (glyph_regs == '0));

    // R10
    reset_blanks_ctl_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_reg == '0));
endmodule

bind dispreg_bus_if dispreg_chk #(.DATA_W(DATA_W), .CHAR_CNT(CHAR_CNT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lo_n   (sel_lo_n),
    .sel_hi     (sel_hi),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe),
    .glyph_regs (glyph_regs),
    .ctl_reg    (ctl_reg)
);

// File: tb/tb_dispreg_bus_if.sv
module tb_dispreg_bus_if;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_lo_n, sel_hi, rd_n, wr_n;
    logic [2:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic [31:0] glyph_regs;
    logic [7:0]  ctl_reg;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dispreg_bus_if dut (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .glyph_regs(glyph_regs),
        .ctl_reg(ctl_reg)
    );

    // Vector: {is_read, addr[2:0], data}; for reads data is the expected value.
    localparam logic [11:0] VEC [14] = '{
        {1'b0, 3'd0, 8'h03},   // control: full brightness
        {1'b0, 3'd7, 8'h53},   // leftmost 'S'
        {1'b0, 3'd6, 8'h54},   // 'T'
        {1'b0, 3'd5, 8'h4F},   // 'O'
        {1'b0, 3'd4, 8'h50},   // rightmost 'P'
        {1'b1, 3'd4, 8'h50},
        {1'b1, 3'd5, 8'h4F},
        {1'b1, 3'd6, 8'h54},
        {1'b1, 3'd7, 8'h53},
        {1'b0, 3'd5, 8'hCF},   // 'O' with attribute flag
        {1'b1, 3'd5, 8'hCF},
        {1'b0, 3'd2, 8'h17},   // control through mirror address 2
        {1'b1, 3'd0, 8'h17},
        {1'b1, 3'd3, 8'h17}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        sel_lo_n = 1'b1; sel_hi = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_write(input logic lo_n, input logic hi, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_lo_n = lo_n; sel_hi = hi; addr = a; wdata = d; wr_n = 1'b0;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic bus_read(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        sel_lo_n = 1'b0; sel_hi = 1'b1; addr = a; rd_n = 1'b0;
        #1;
        check("R3", {31'd0, rdata_oe}, 32'd1);
        check(req, {24'd0, rdata}, {24'd0, exp});
        idle_bus();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_bus(); addr = '0; wdata = '0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        check("R10", {24'd0, ctl_reg}, 32'h0);
        check("R10", {31'd0, rdata_oe}, 32'd0);

        // Table walk: R4, R5, R11
        foreach (VEC[i]) begin
            if (VEC[i][11])
                bus_read(VEC[i][10] ? "R4/R11" : "R5", VEC[i][10:8], VEC[i][7:0]);
            else
                bus_write(1'b0, 1'b1, VEC[i][10:8], VEC[i][7:0]);
        end
        @(negedge clk);
        check("R4", glyph_regs, 32'h5354CF50);
        check("R5", {24'd0, ctl_reg}, 32'h17);

        // R1: writes under each deselecting enable combination
        bus_write(1'b1, 1'b1, 3'd0, 8'h55);
        bus_write(1'b0, 1'b0, 3'd4, 8'h21);
        bus_write(1'b1, 1'b0, 3'd6, 8'h22);
        check("R1", {24'd0, ctl_reg}, 32'h17);
        check("R1", glyph_regs, 32'h5354CF50);
        @(negedge clk);
        sel_lo_n = 1'b1; sel_hi = 1'b1; rd_n = 1'b0; addr = 3'd0; #1;
        check("R1", {31'd0, rdata_oe}, 32'd0);
        idle_bus();

        // R2: both strobes low is no operation
        @(negedge clk);
        sel_lo_n = 1'b0; sel_hi = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
        addr = 3'd1; wdata = 8'hAA; #1;
        check("R2", {31'd0, rdata_oe}, 32'd0);
        @(negedge clk);
        idle_bus();
        check("R2", {24'd0, ctl_reg}, 32'h17);

        // R6: held strobe commits only the first value
        @(negedge clk);
        sel_lo_n = 1'b0; sel_hi = 1'b1; addr = 3'd6; wdata = 8'h41; wr_n = 1'b0;
        @(negedge clk) wdata = 8'h42;
        @(negedge clk) begin wdata = 8'h43; addr = 3'd4; end
        @(negedge clk) idle_bus();
        bus_read("R6", 3'd6, 8'h41);
        bus_read("R6", 3'd4, 8'h50);

        // R7: clear command zeroes everything at its commit edge
        bus_write(1'b0, 1'b1, 3'd1, 8'h80);
        check("R7", glyph_regs, 32'h0);
        bus_read("R7", 3'd7, 8'h00);

        // R8: character write during clear is dropped
        bus_write(1'b0, 1'b1, 3'd7, 8'h5A);
        check("R8", glyph_regs, 32'h0);
        bus_read("R8", 3'd7, 8'h00);

        // R9: release clear, then writes work again
        bus_write(1'b0, 1'b1, 3'd3, 8'h03);
        bus_read("R9", 3'd0, 8'h03);
        check("R9", glyph_regs, 32'h0);
        bus_write(1'b0, 1'b1, 3'd7, 8'h5A);
        bus_read("R9", 3'd7, 8'h5A);

        // R10: reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R10", {24'd0, ctl_reg}, 32'h0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule